// File: doc/BRIEF.md
# Persistent Exception Status and Interrupt Gating

This block gathers exception events from seven sources, keeps a sticky status bit for those that need one, and turns pending conditions into two interrupt request lines: one for the critical class and one for the noncritical class. Each request is gated by the enable bit of its class. A 3-bit cause code names the highest-priority source that is requesting in the current cycle.

Its sources do not all persist in the same way. Both timer sources and the imprecise debug status stay pending until software clears them. The watchdog raises a request only on the timeout that sets its status bit. Machine check records status but requests only while the bus-error pulse is present. The critical and noncritical external inputs are level signals whose status is held by an outside controller, so they are passed through gated and are not latched.

Software clears status by pulsing `clr_we` with a one in each bit of `clr_mask` that is to be cleared. The timer, debug, watchdog and bus-error events come in as single-cycle pulses from logic outside this block.

Top module: `exc_persist_gate`

## Requirements
- R1: After reset `status` is 0, `crit_req` and `ext_req` are low, and `cause` is 0 (code 0 means no request).
- R2: `pit_evt` sets `status[0]` and `fit_evt` sets `status[1]`. Both bits are sticky. While either bit is set and `en_ext` is high, `ext_req` is high.
- R3: `dbg_evt` while `en_dbg` is low sets `status[2]`. While `status[2]` is set and `en_dbg` is high, `crit_req` is high. `dbg_evt` while `en_dbg` is high requests in that same cycle and leaves `status[2]` unchanged.
- R4: `wdt_evt` while `status[3]` is clear sets `status[3]`. In that same cycle it raises `crit_req` if `en_crit` is high.
- R5: `wdt_evt` while `status[3]` is already set raises no request. Once `status[3]` is cleared, the next timeout requests again.
- R6: `mchk_evt` sets `status[4]`. A machine-check request (on `crit_req`) exists only in a cycle where `mchk_evt` and `en_mchk` are both high. Raising `en_mchk` while `status[4]` is set does not by itself request.
- R7: `crit_in` with `en_crit` drives `crit_req`, and `ext_in` with `en_ext` drives `ext_req`, in the same cycle. Neither input is latched.
- R8: A status bit clears on the clock edge where `clr_we` is high and the matching `clr_mask` bit is 1. If a set event reaches the same bit in that cycle, the set wins.
- R9: `cause` encodes the winning requester, highest priority first: 1 machine check, 2 critical input, 3 watchdog, 4 debug, 5 external input, 6 programmable-interval timer, 7 fixed-interval timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_in | input | 1 | Critical external input, level |
| ext_in | input | 1 | Noncritical external input, level |
| pit_evt | input | 1 | Programmable-interval timer event pulse |
| fit_evt | input | 1 | Fixed-interval timer event pulse |
| dbg_evt | input | 1 | Debug event pulse |
| wdt_evt | input | 1 | Watchdog timeout pulse |
| mchk_evt | input | 1 | Bus-error pulse for machine check |
| en_crit | input | 1 | Critical-class enable |
| en_ext | input | 1 | Noncritical-class enable |
| en_dbg | input | 1 | Debug enable |
| en_mchk | input | 1 | Machine-check enable |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 5 | Write-one-to-clear mask, same bit layout as status |
| status | output | 5 | Sticky status: 0 pit, 1 fit, 2 debug, 3 watchdog, 4 machine check |
| crit_req | output | 1 | Critical-class interrupt request |
| ext_req | output | 1 | Noncritical-class interrupt request |
| cause | output | 3 | Code of the highest-priority requester |

## Verification
A wrong status bit shows on `status` one edge after the event or clear that should have set or cleared it. When the class is enabled, it also shows at once on `crit_req`, `ext_req` or `cause`. The errors that matter most depend on history: a watchdog that requests again while its bit is set, a machine check that requests only because `en_mchk` was raised, or a clear that beats a set. The bench drives these cases directly and compares every output in every cycle against a model that tracks status from the requirements.

// File: rtl/exc_persist_gate.sv
module exc_persist_gate #(
  parameter int NSTS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            crit_in,
  input  logic            ext_in,
  input  logic            pit_evt,
  input  logic            fit_evt,
  input  logic            dbg_evt,
  input  logic            wdt_evt,
  input  logic            mchk_evt,
  input  logic            en_crit,
  input  logic            en_ext,
  input  logic            en_dbg,
  input  logic            en_mchk,
  input  logic            clr_we,
  input  logic [NSTS-1:0] clr_mask,
  output logic [NSTS-1:0] status,
  output logic            crit_req,
  output logic            ext_req,
  output logic [2:0]      cause
);
  localparam int B_PIT = 0, B_FIT = 1, B_DBG = 2, B_WDT = 3, B_MCK = 4;

  logic [NSTS-1:0] sts_q, set_v, clr_v;
  logic mchk_req, cin_req, wdt_req, dbg_req, xin_req, pit_req, fit_req;

  always_comb begin
    set_v        = '0;
    set_v[B_PIT] = pit_evt;
    set_v[B_FIT] = fit_evt;
    set_v[B_DBG] = dbg_evt & ~en_dbg;
    set_v[B_WDT] = wdt_evt;
    set_v[B_MCK] = mchk_evt;
  end

  assign clr_v = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_v) | set_v;
  end

  assign mchk_req = en_mchk & mchk_evt;
  assign cin_req  = en_crit & crit_in;
  assign wdt_req  = en_crit & wdt_evt & ~sts_q[B_WDT];
  assign dbg_req  = en_dbg & (sts_q[B_DBG] | dbg_evt);
  assign xin_req  = en_ext & ext_in;
  assign pit_req  = en_ext & sts_q[B_PIT];
  assign fit_req  = en_ext & sts_q[B_FIT];

  assign crit_req = mchk_req | cin_req | wdt_req | dbg_req;
  assign ext_req  = xin_req | pit_req | fit_req;
  assign status   = sts_q;

  always_comb begin
    if      (mchk_req) cause = 3'd1;
    else if (cin_req)  cause = 3'd2;
    else if (wdt_req)  cause = 3'd3;
    else if (dbg_req)  cause = 3'd4;
    else if (xin_req)  cause = 3'd5;
    else if (pit_req)  cause = 3'd6;
    else if (fit_req)  cause = 3'd7;
    else               cause = 3'd0;
  end
endmodule

// File: rtl/exc_persist_gate_chk.sv
module exc_persist_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       crit_in,
  input logic       en_crit,
  input logic       wdt_evt,
  input logic       mchk_evt,
  input logic       pit_evt,
  input logic       clr_we,
  input logic [4:0] clr_mask,
  input logic [4:0] status,
  input logic       crit_req,
  input logic       ext_req,
  input logic [2:0] cause,
  input logic       wdt_req
);
  a_r1_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 3'd0) |-> (!crit_req && !ext_req));
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(clr_we && clr_mask[0])) |=> status[0]);
  a_r5_wdt_once: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && wdt_evt) |-> !wdt_req);
  a_r6_mchk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 3'd1) |-> mchk_evt);
  a_r7_crit_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_in && en_crit) |-> crit_req);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[0] && pit_evt) |=> status[0]);
  a_r4_wdt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_evt |=> status[3]);
endmodule

bind exc_persist_gate exc_persist_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crit_in(crit_in), .en_crit(en_crit),
  .wdt_evt(wdt_evt), .mchk_evt(mchk_evt), .pit_evt(pit_evt),
  .clr_we(clr_we), .clr_mask(clr_mask), .status(status),
  .crit_req(crit_req), .ext_req(ext_req), .cause(cause), .wdt_req(wdt_req)
);

// File: tb/tb_exc_persist_gate.sv
module tb_exc_persist_gate;
  logic clk = 0, rst_n = 0;
  logic crit_in, ext_in, pit_evt, fit_evt, dbg_evt, wdt_evt, mchk_evt;
  logic en_crit, en_ext, en_dbg, en_mchk, clr_we;
  logic [4:0] clr_mask, status;
  logic crit_req, ext_req;
  logic [2:0] cause;
  int checks = 0, errors = 0;
  logic [4:0] m_sts;

  always #5 clk = ~clk;

  exc_persist_gate dut (.*);

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_cause(logic [4:0] s);
    if (en_mchk && mchk_evt) return 3'd1;
    if (en_crit && crit_in) return 3'd2;
    if (en_crit && wdt_evt && !s[3]) return 3'd3;
    if (en_dbg && (s[2] || dbg_evt)) return 3'd4;
    if (en_ext && ext_in) return 3'd5;
    if (en_ext && s[0]) return 3'd6;
    if (en_ext && s[1]) return 3'd7;
    return 3'd0;
  endfunction

  function automatic logic [4:0] next_sts(logic [4:0] s);
    logic [4:0] st;
    st = {mchk_evt, wdt_evt, dbg_evt & ~en_dbg, fit_evt, pit_evt};
    return (s & ~(clr_we ? clr_mask : 5'd0)) | st;
  endfunction

  task automatic idle();
    {crit_in, ext_in, pit_evt, fit_evt, dbg_evt, wdt_evt, mchk_evt} = '0;
    {en_crit, en_ext, en_dbg, en_mchk, clr_we} = '0;
    clr_mask = '0;
  endtask

  // inputs already driven after a negedge; checks outputs, then steps model over one edge
  task automatic step();
    logic [2:0] c;
    #1;
    c = exp_cause(m_sts);
    chk("R8 status", status, m_sts);
    chk("R9 cause", cause, c);
    chk("R7 crit_req", crit_req, (c >= 1 && c <= 4));
    chk("R2 ext_req", ext_req, (en_ext && (ext_in || m_sts[0] || m_sts[1])));
    @(posedge clk);
    m_sts = next_sts(m_sts);
    @(negedge clk);
    idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle();
    m_sts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 status", status, 0);
    chk("R1 crit_req", crit_req, 0);
    chk("R1 ext_req", ext_req, 0);
    chk("R1 cause", cause, 0);

    // R5: watchdog requests once, then silent until cleared
    en_crit = 1; wdt_evt = 1; #1;
    chk("R4 first timeout crit_req", crit_req, 1);
    chk("R4 cause", cause, 3);
    step();
    chk("R4 status[3]", status[3], 1);
    en_crit = 1; wdt_evt = 1; #1;
    chk("R5 repeat timeout crit_req", crit_req, 0);
    step();
    clr_we = 1; clr_mask = 5'b01000; step();
    en_crit = 1; wdt_evt = 1; #1;
    chk("R5 rearmed crit_req", crit_req, 1);
    step();
    clr_we = 1; clr_mask = 5'b01000; step();

    // R6: machine check not raised by enabling with status set
    mchk_evt = 1; step();
    chk("R6 status[4]", status[4], 1);
    en_mchk = 1; #1;
    chk("R6 enable alone crit_req", crit_req, 0);
    step();
    en_mchk = 1; mchk_evt = 1; #1;
    chk("R6 pulse crit_req", crit_req, 1);
    chk("R6 pulse cause", cause, 1);
    step();

    // R3: imprecise debug
    dbg_evt = 1; step();
    chk("R3 status[2] set while disabled", status[2], 1);
    en_dbg = 1; #1;
    chk("R3 later enable crit_req", crit_req, 1);
    chk("R3 cause", cause, 4);
    clr_we = 1; clr_mask = 5'b00100; step();
    en_dbg = 1; dbg_evt = 1; #1;
    chk("R3 enabled event crit_req", crit_req, 1);
    step();
    chk("R3 enabled event not latched", status[2], 0);

    // R8: set wins over clear; R2 sticky timers
    pit_evt = 1; fit_evt = 1; step();
    pit_evt = 1; clr_we = 1; clr_mask = 5'b00011; step();
    chk("R8 set wins", status[1:0], 2'b01);
    en_ext = 1; #1;
    chk("R2 ext_req from pit", ext_req, 1);
    chk("R9 pit cause", cause, 6);
    step();
    // R7 level inputs not latched
    ext_in = 1; crit_in = 1; #1;
    chk("R7 crit_in gated off", crit_req, 0);
    en_crit = 1; en_ext = 1; #1;
    chk("R7 crit_in pass", crit_req, 1);
    chk("R9 crit over ext", cause, 2);
    step();
    en_crit = 1; #1;
    chk("R7 not latched", crit_req, 0);
    step();

    for (int i = 0; i < 3000; i++) begin
      crit_in  = ($urandom % 6) == 0;
      ext_in   = ($urandom % 6) == 0;
      pit_evt  = ($urandom % 8) == 0;
      fit_evt  = ($urandom % 8) == 0;
      dbg_evt  = ($urandom % 8) == 0;
      wdt_evt  = ($urandom % 8) == 0;
      mchk_evt = ($urandom % 10) == 0;
      en_crit  = $urandom % 2;
      en_ext   = $urandom % 2;
      en_dbg   = $urandom % 2;
      en_mchk  = $urandom % 2;
      clr_we   = ($urandom % 4) == 0;
      clr_mask = 5'($urandom);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule